// File: doc/BRIEF.md
# Extended Interrupt Set-Pending Register Bank

This block holds the pending and active state of 64 extended per-processor interrupts and exposes the pending view through two 32-bit write-one-to-set registers on a simple memory-mapped bus. Each interrupt has its own four-state machine. The states are `XS_IDLE` (inactive, nothing latched), `XS_LATCHED` (a software pend is latched and the interrupt is not active), `XS_ACTIVE` (active, nothing latched) and `XS_ACT_LATCHED` (active with a software pend latched). An interrupt is visible as pending when its software latch is set or its level input is high.

Software pends are kept apart from the level input, so a pend written by software survives the input line dropping. Acknowledge, deactivate and clear-pending strobes come from the neighbouring priority and CPU-interface logic. Every bit passes through an access filter before it is read or written. The filter makes the bit read as zero and ignore writes when the interrupt is not implemented, when affinity routing is off for its security group, or when a non-secure access targets a secure interrupt while the security-disable control is low.

The named transitions are:
- **set**: IDLE→LATCHED, ACTIVE→ACT_LATCHED.
- **acknowledge**: IDLE or LATCHED→ACTIVE, only when visibly pending.
- **deactivate**: ACTIVE→IDLE, ACT_LATCHED→LATCHED.
- **clear**: LATCHED→IDLE, ACT_LATCHED→ACTIVE.

Top module: `xpend_bank`

## Requirements
- R1: Register n (n = 1, 2) is decoded at byte offset 0x200 + 4*n, so 0x204 holds interrupts 0..31 and 0x208 holds 32..63, with bit x of register n being interrupt 32*(n-1)+x. Any other address reads 0 and ignores writes.
- R2: Writing 1 to an accessible bit sets that interrupt's software latch (IDLE→LATCHED, ACTIVE→ACT_LATCHED). Writing 0 has no effect.
- R3: A read returns, on `bus_rdata` one clock after the request, the pending view (latch OR level) of the 32 interrupts of the addressed register.
- R4: A high level input makes the interrupt read as pending. A software-latched interrupt stays pending after its level input drops.
- R5: An acknowledge strobe on a pending, non-active interrupt makes it active and clears its software latch.
- R6: A deactivate strobe moves ACTIVE to IDLE and ACT_LATCHED to LATCHED, leaving the pend in place.
- R7: A clear-pending strobe clears the software latch. When it coincides with a set write, the set wins.
- R8: Writing 1 to an active interrupt makes it active and pending, and it stays active.
- R9: When `sec_disable` is 0, non-secure accesses read secure-group bits as 0 and cannot set them. When `sec_disable` is 1 they can. The default secure group is interrupts 0..7 and 32..39.
- R10: Unimplemented interrupts (default: 28..31) read as 0 and ignore writes.
- R11: When affinity routing is off for an interrupt's group (`affrt_sec` for secure, `affrt_nsec` for non-secure), its bit reads as 0 and ignores writes.
- R12: After reset every interrupt is IDLE with its latch clear, and the bank reads as 0 while all level inputs are low.
- R13: A set write and an acknowledge in the same cycle leave the interrupt in ACT_LATCHED, so it is both active and pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the frame |
| bus_wdata | input | 32 | Write data, one bit per interrupt |
| bus_nonsec | input | 1 | Access is non-secure |
| sec_disable | input | 1 | Security-disable control |
| affrt_sec | input | 1 | Affinity routing enabled for the secure group |
| affrt_nsec | input | 1 | Affinity routing enabled for the non-secure group |
| irq_level | input | 64 | Level-sensitive interrupt inputs |
| ack_strobe | input | 64 | Acknowledge strobes |
| deact_strobe | input | 64 | Deactivate strobes |
| clrpend_strobe | input | 64 | Clear-pending strobes |
| bus_rdata | output | 32 | Read data, valid one cycle after a read |
| pend_out | output | 64 | Pending view per interrupt |
| active_out | output | 64 | Active flag per interrupt |

## Verification
A software set can land in the same cycle as an acknowledge, and separately in the same cycle as a clear-pending strobe. The bench provokes the first by holding a level input high and then driving the acknowledge strobe together with a write of 1 to the same bit. It judges the result by the interrupt being active and still reading pending after the level drops. It provokes the second by pulsing clear-pending together with the set write, and expects the pend to survive.

// File: rtl/xpend_pkg.sv
package xpend_pkg;
    // bit1 = active, bit0 = software latch
    typedef enum logic [1:0] {
        XS_IDLE        = 2'b00,
        XS_LATCHED     = 2'b01,
        XS_ACTIVE      = 2'b10,
        XS_ACT_LATCHED = 2'b11
    } xs_state_e;
endpackage

// File: rtl/xpend_decode.sv
module xpend_decode #(
    parameter int ADDR_W   = 12,
    parameter int BASE_OFF = 'h200,
    parameter int NUM_REGS = 2
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel,
    output logic                hit
);
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
        localparam int OFF = BASE_OFF + 4 * (r + 1);
        assign sel[r] = (addr == ADDR_W'(OFF));
    end
    assign hit = |sel;
endmodule

// File: rtl/xpend_filter.sv
module xpend_filter #(
    parameter int          N         = 64,
    parameter logic [63:0] IMPL_MASK = 64'hFFFF_FFFF_0FFF_FFFF,
    parameter logic [63:0] SEC_GROUP = 64'h0000_00FF_0000_00FF
) (
    input  logic         nonsec,
    input  logic         sec_disable,
    input  logic         affrt_sec,
    input  logic         affrt_nsec,
    output logic [N-1:0] acc_mask
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        if (!IMPL_MASK[i]) begin : g_absent
            assign acc_mask[i] = 1'b0;
        end else if (SEC_GROUP[i]) begin : g_secure
            assign acc_mask[i] = affrt_sec & (sec_disable | ~nonsec);
        end else begin : g_nonsecure
            assign acc_mask[i] = affrt_nsec;
        end
    end
endmodule

// File: rtl/xpend_cell.sv
module xpend_cell
    import xpend_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic set,
    input  logic ack,
    input  logic deact,
    input  logic clr,
    output logic pend,
    output logic active
);
    xs_state_e state, nxt;
    logic      drop;

    assign drop = clr & ~set;

    always_comb begin
        nxt = state;
        unique case (state)
            XS_IDLE: begin
                if (ack && lvl)   nxt = set ? XS_ACT_LATCHED : XS_ACTIVE;
                else if (set)     nxt = XS_LATCHED;
                else              nxt = XS_IDLE;
            end
            XS_LATCHED: begin
                if (ack)          nxt = set ? XS_ACT_LATCHED : XS_ACTIVE;
                else if (drop)    nxt = XS_IDLE;
                else              nxt = XS_LATCHED;
            end
            XS_ACTIVE: begin
                if (deact)        nxt = set ? XS_LATCHED : XS_IDLE;
                else              nxt = set ? XS_ACT_LATCHED : XS_ACTIVE;
            end
            XS_ACT_LATCHED: begin
                if (deact)        nxt = drop ? XS_IDLE : XS_LATCHED;
                else              nxt = drop ? XS_ACTIVE : XS_ACT_LATCHED;
            end
            default:              nxt = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= XS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        unique case (state)
            XS_IDLE:        begin pend = lvl;  active = 1'b0; end
            XS_LATCHED:     begin pend = 1'b1; active = 1'b0; end
            XS_ACTIVE:      begin pend = lvl;  active = 1'b1; end
            XS_ACT_LATCHED: begin pend = 1'b1; active = 1'b1; end
            default:        begin pend = 1'b0; active = 1'b0; end
        endcase
    end
endmodule

// File: rtl/xpend_bank.sv
module xpend_bank #(
    parameter int          NUM_REGS  = 2,
    parameter int          REG_W     = 32,
    parameter int          ADDR_W    = 12,
    parameter int          BASE_OFF  = 'h200,
    parameter logic [63:0] IMPL_MASK = 64'hFFFF_FFFF_0FFF_FFFF,
    parameter logic [63:0] SEC_GROUP = 64'h0000_00FF_0000_00FF,
    localparam int         NUM_IRQ   = NUM_REGS * REG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    input  logic               bus_nonsec,
    input  logic               sec_disable,
    input  logic               affrt_sec,
    input  logic               affrt_nsec,
    input  logic [NUM_IRQ-1:0] irq_level,
    input  logic [NUM_IRQ-1:0] ack_strobe,
    input  logic [NUM_IRQ-1:0] deact_strobe,
    input  logic [NUM_IRQ-1:0] clrpend_strobe,
    output logic [REG_W-1:0]   bus_rdata,
    output logic [NUM_IRQ-1:0] pend_out,
    output logic [NUM_IRQ-1:0] active_out
);
    logic [NUM_REGS-1:0] sel;
    logic                hit;
    logic [NUM_IRQ-1:0]  acc_mask;
    logic [NUM_IRQ-1:0]  set_vec;
    logic [NUM_IRQ-1:0]  cell_pend;
    logic [NUM_IRQ-1:0]  cell_act;
    logic                wr_en;
    logic                rd_en;
    logic [REG_W-1:0]    rd_word;
    logic [REG_W-1:0]    acc_word;

    assign wr_en = bus_valid & bus_write & hit;
    assign rd_en = bus_valid & ~bus_write;

    xpend_decode #(
        .ADDR_W  (ADDR_W),
        .BASE_OFF(BASE_OFF),
        .NUM_REGS(NUM_REGS)
    ) u_decode (
        .addr(bus_addr),
        .sel (sel),
        .hit (hit)
    );

    xpend_filter #(
        .N        (NUM_IRQ),
        .IMPL_MASK(IMPL_MASK),
        .SEC_GROUP(SEC_GROUP)
    ) u_filter (
        .nonsec     (bus_nonsec),
        .sec_disable(sec_disable),
        .affrt_sec  (affrt_sec),
        .affrt_nsec (affrt_nsec),
        .acc_mask   (acc_mask)
    );

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        assign set_vec[r*REG_W +: REG_W] =
            {REG_W{wr_en & sel[r]}} & bus_wdata & acc_mask[r*REG_W +: REG_W];
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        xpend_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (irq_level[i] & IMPL_MASK[i]),
            .set   (set_vec[i]),
            .ack   (ack_strobe[i]),
            .deact (deact_strobe[i]),
            .clr   (clrpend_strobe[i]),
            .pend  (cell_pend[i]),
            .active(cell_act[i])
        );
    end

    assign pend_out   = cell_pend & IMPL_MASK[NUM_IRQ-1:0];
    assign active_out = cell_act  & IMPL_MASK[NUM_IRQ-1:0];

    always_comb begin
        rd_word  = '0;
        acc_word = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (sel[r]) begin
                acc_word = acc_word | acc_mask[r*REG_W +: REG_W];
                rd_word  = rd_word | (pend_out[r*REG_W +: REG_W] & acc_mask[r*REG_W +: REG_W]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_en) bus_rdata <= rd_word;
    end
endmodule

// File: rtl/xpend_bank_chk.sv
module xpend_bank_chk #(
    parameter int N = 64,
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_valid,
    input logic         bus_write,
    input logic [W-1:0] bus_rdata,
    input logic [W-1:0] acc_word,
    input logic [N-1:0] set_vec,
    input logic [N-1:0] ack_strobe,
    input logic [N-1:0] deact_strobe,
    input logic [N-1:0] pend_out,
    input logic [N-1:0] active_out
);
    AST_RAZ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> ((bus_rdata & ~$past(acc_word)) == '0)); // R9

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_SET_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> pend_out[i]); // R2
        AST_ACK_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_strobe[i] && pend_out[i] && !active_out[i]) |=> active_out[i]); // R5
        AST_DEACT_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
            (active_out[i] && deact_strobe[i]) |=> !active_out[i]); // R6
        AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (active_out[i] && !deact_strobe[i]) |=> active_out[i]); // R8
    end
endmodule

bind xpend_bank xpend_bank_chk #(
    .N(NUM_IRQ),
    .W(REG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_rdata   (bus_rdata),
    .acc_word    (acc_word),
    .set_vec     (set_vec),
    .ack_strobe  (ack_strobe),
    .deact_strobe(deact_strobe),
    .pend_out    (pend_out),
    .active_out  (active_out)
);

// File: tb/xpend_bank_tb_top.sv
`timescale 1ns/1ps
module xpend_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_nonsec = 1'b0;
    logic        sec_disable = 1'b0;
    logic        affrt_sec = 1'b1;
    logic        affrt_nsec = 1'b1;
    logic [63:0] irq_level = '0;
    logic [63:0] ack_strobe = '0;
    logic [63:0] deact_strobe = '0;
    logic [63:0] clrpend_strobe = '0;
    logic [31:0] bus_rdata;
    logic [63:0] pend_out;
    logic [63:0] active_out;

    int          n_checks = 0;
    int          n_fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    xpend_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_nonsec(bus_nonsec),
        .sec_disable(sec_disable), .affrt_sec(affrt_sec), .affrt_nsec(affrt_nsec),
        .irq_level(irq_level), .ack_strobe(ack_strobe), .deact_strobe(deact_strobe),
        .clrpend_strobe(clrpend_strobe), .bus_rdata(bus_rdata),
        .pend_out(pend_out), .active_out(active_out)
    );

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(tag);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic pulse(ref logic [63:0] v, input int idx);
        @(negedge clk);
        v[idx] = 1'b1;
        @(negedge clk);
        v[idx] = 1'b0;
    endtask

    task automatic chk_act(input int idx, input logic e, input string tag);
        n_checks++;
        if (active_out[idx] !== e) begin
            n_fails++;
            $display("FAIL %s: active_out[%0d] actual %b expected %b", tag, idx, active_out[idx], e);
        end
    endtask

    // monitor: pops the scoreboard one cycle after each read request
    initial begin
        logic rd_seen;
        forever begin
            @(posedge clk);
            rd_seen = rst_n && bus_valid && !bus_write;
            @(negedge clk);
            if (rd_seen) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front(); t = tag_q.pop_front();
                n_checks++;
                if (bus_rdata !== e) begin
                    n_fails++;
                    $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        do_read(12'h204, 32'h0, "R12 reg1");
        do_read(12'h208, 32'h0, "R12 reg2");
        chk_act(0, 1'b0, "R12");
        // R2 / R3 set and write-zero
        do_write(12'h204, 32'h5);
        do_read(12'h204, 32'h5, "R2 set");
        do_write(12'h204, 32'h0);
        do_read(12'h204, 32'h5, "R2 write zero");
        // R1 decode
        do_write(12'h208, 32'h1);
        do_read(12'h208, 32'h1, "R1 reg2");
        do_read(12'h204, 32'h5, "R1 reg1 untouched");
        do_read(12'h20C, 32'h0, "R1 bad read");
        do_write(12'h200, 32'hFFFF_FFFF);
        do_read(12'h204, 32'h5, "R1 bad write reg1");
        do_read(12'h208, 32'h1, "R1 bad write reg2");
        // R10 unimplemented
        do_write(12'h204, 32'hF000_0000);
        do_read(12'h204, 32'h5, "R10");
        // R4 level vs latch
        @(negedge clk); irq_level[10] = 1'b1;
        do_read(12'h204, 32'h405, "R4 level");
        do_write(12'h204, 32'h400);
        @(negedge clk); irq_level[11] = 1'b1;
        do_read(12'h204, 32'hC05, "R4 level two");
        @(negedge clk); irq_level[10] = 1'b0; irq_level[11] = 1'b0;
        do_read(12'h204, 32'h405, "R4 latch holds");
        // R5 / R8 / R6
        pulse(ack_strobe, 0);
        chk_act(0, 1'b1, "R5");
        do_read(12'h204, 32'h404, "R5 latch cleared");
        do_write(12'h204, 32'h1);
        chk_act(0, 1'b1, "R8");
        do_read(12'h204, 32'h405, "R8 active pending");
        pulse(deact_strobe, 0);
        chk_act(0, 1'b0, "R6 to pending");
        do_read(12'h204, 32'h405, "R6 pend kept");
        pulse(ack_strobe, 0);
        pulse(deact_strobe, 0);
        chk_act(0, 1'b0, "R6 to idle");
        do_read(12'h204, 32'h404, "R6 idle");
        // R7 clear, and clear against set
        pulse(clrpend_strobe, 2);
        do_read(12'h204, 32'h400, "R7 clear");
        @(negedge clk);
        clrpend_strobe[10] = 1'b1;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'h204; bus_wdata = 32'h400;
        @(negedge clk);
        clrpend_strobe[10] = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
        do_read(12'h204, 32'h400, "R7 set wins");
        // R13 set with acknowledge
        @(negedge clk); irq_level[5] = 1'b1;
        @(negedge clk);
        ack_strobe[5] = 1'b1;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'h204; bus_wdata = 32'h20;
        @(negedge clk);
        ack_strobe[5] = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
        chk_act(5, 1'b1, "R13 active");
        irq_level[5] = 1'b0;
        do_read(12'h204, 32'h420, "R13 pending");
        pulse(deact_strobe, 5);
        chk_act(5, 1'b0, "R13 deact");
        do_read(12'h204, 32'h420, "R13 latched");
        pulse(clrpend_strobe, 5);
        do_read(12'h204, 32'h400, "R13 cleared");
        // R9 security gating
        bus_nonsec = 1'b1;
        do_read(12'h204, 32'h400, "R9 ns read");
        do_write(12'h204, 32'h8);
        bus_nonsec = 1'b0;
        do_read(12'h204, 32'h400, "R9 ns write ignored");
        do_write(12'h204, 32'h8);
        do_read(12'h204, 32'h408, "R9 secure write");
        bus_nonsec = 1'b1;
        do_read(12'h204, 32'h400, "R9 secure bit hidden");
        sec_disable = 1'b1;
        do_read(12'h204, 32'h408, "R9 disable read");
        do_write(12'h204, 32'h10);
        bus_nonsec = 1'b0; sec_disable = 1'b0;
        do_read(12'h204, 32'h418, "R9 disable write");
        // R11 affinity routing gating
        affrt_sec = 1'b0;
        do_read(12'h204, 32'h400, "R11 sec off read");
        do_write(12'h204, 32'h40);
        affrt_sec = 1'b1;
        do_read(12'h204, 32'h418, "R11 sec off write ignored");
        affrt_nsec = 1'b0;
        do_read(12'h204, 32'h18, "R11 nsec off read");
        affrt_nsec = 1'b1;
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_checks++; n_fails++;
            $display("FAIL R3: reads answered actual %0d short expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule